// File: doc/BRIEF.md
# Two-Way Set-Associative Address Translation Buffer

This block caches recent virtual-to-physical page mappings for a 16-bit address space split into 256-byte pages. A requester presents a virtual address on the lookup port. The block registers it. During the following cycle it reports whether a stored mapping covers that page and, on a hit, the physical address. The physical address is the stored physical page number placed above the untranslated page offset.

The virtual page number is the upper byte of the address. Its two low bits pick one of four sets, and its six high bits form the tag. Both ways of the selected set are compared in parallel.

A miss handler, which is outside this block, installs new mappings through the fill port. The fill reuses a way that already holds the same tag. Failing that, it takes an empty way. When both ways are full, it replaces the way the per-set recency bit names. A single invalidate input empties the whole buffer in one cycle.

Top module: `tlb2w`

## Requirements
- R1: Bits [7:0] of `lk_paddr` equal bits [7:0] of the captured lookup address. The result for an address captured at a rising edge is presented during the cycle that follows that edge. `lk_hit` is 0 in any cycle where no lookup was captured at the preceding edge.
- R2: The page number is `lk_vaddr[15:8]`. Its bits [1:0] select the set (0..3), and its bits [7:2] are the 6-bit tag.
- R3: A hit needs a way of the selected set whose valid bit is 1 and whose tag is equal to the address tag. On a hit, `lk_paddr[15:8]` is that way's page number. On a miss, `lk_paddr[15:8]` is 0. A way whose tag matches but whose valid bit is 0 gives a miss.
- R4: A fill stores the tag and page number taken from `fill_vpn` and `fill_ppn` into the set named by `fill_vpn[1:0]`, and marks that way valid. A lookup captured at the same edge already sees the new entry.
- R5: If a valid way of the target set already holds the fill's tag, the fill overwrites that way. The other way is left untouched.
- R6: Otherwise the fill takes way 0 if it is invalid. If way 0 is valid, it takes way 1 if that is invalid. If both ways are valid, it takes the way named by the set's recency bit.
- R7: A hit in way w, or a fill into way w, makes the other way of that set the next replacement choice.
- R8: Reset leaves every entry invalid, with way 0 as each set's replacement choice. `inv_all` clears every valid bit in one cycle, and it overrides a fill at the same edge.
- R9: Load set 0 with tag 0x13 and page 0x30, set 1 with tag 0x2A and page 0x72, set 2 with tag 0x1F and page 0x95, and set 3 with tag 0x3F and page 0x20. A lookup of 0x7E85 then hits and returns 0x9585.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Clear all valid bits |
| lk_valid | input | 1 | Lookup request, captured at the edge |
| lk_vaddr | input | 16 | Virtual address to translate |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | 8 | Virtual page number of the mapping |
| fill_ppn | input | 8 | Physical page number of the mapping |
| lk_hit | output | 1 | Captured lookup hit |
| lk_paddr | output | 16 | Translated physical address |

## Verification
A lookup result is due one edge after the request: the edge captures the address, and the bench samples the outputs at the falling edge that follows it. A fill or an invalidate takes effect at the edge that samples it. A recency update caused by a hit lands at the edge after the result is shown. To respect this, the bench drops the request at that same falling edge, so every later operation starts only after the update has landed. Expected values come from a small array model in the bench that updates in that same order. The model is run through full page-number sweeps and a random phase with few distinct tags, which forces overwrites and evictions.

// File: rtl/tlb2w.sv
module tlb2w #(
  parameter int VA_W  = 16,
  parameter int PA_W  = 16,
  parameter int OFF_W = 8,
  parameter int SET_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inv_all,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic                  fill_en,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  output logic                  lk_hit,
  output logic [PA_W-1:0]       lk_paddr
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int SETS  = 1 << SET_W;

  logic [1:0]       vld [SETS];
  logic [TAG_W-1:0] tag [SETS][2];
  logic [PPN_W-1:0] ppn [SETS][2];
  logic [SETS-1:0]  lru;

  logic            q_v;
  logic [VA_W-1:0] q_va;

  wire [SET_W-1:0] l_set = q_va[OFF_W +: SET_W];
  wire [TAG_W-1:0] l_tag = q_va[OFF_W+SET_W +: TAG_W];
  wire [SET_W-1:0] f_set = fill_vpn[SET_W-1:0];
  wire [TAG_W-1:0] f_tag = fill_vpn[VPN_W-1:SET_W];
  wire             f_do  = fill_en && !inv_all;

  logic [1:0] l_match, f_match;
  logic       f_way;

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      l_match[w] = q_v && vld[l_set][w] && (tag[l_set][w] == l_tag);
      f_match[w] = vld[f_set][w] && (tag[f_set][w] == f_tag);
    end
    if (|f_match)              f_way = f_match[1];
    else if (!vld[f_set][0])   f_way = 1'b0;
    else if (!vld[f_set][1])   f_way = 1'b1;
    else                       f_way = lru[f_set];
  end

  assign lk_hit   = |l_match;
  assign lk_paddr = {l_match[1] ? ppn[l_set][1] :
                     l_match[0] ? ppn[l_set][0] : {PPN_W{1'b0}},
                     q_va[OFF_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v  <= 1'b0;
      q_va <= '0;
      lru  <= '0;
      for (int s = 0; s < SETS; s++) vld[s] <= 2'b00;
    end else begin
      q_v  <= lk_valid;
      q_va <= lk_vaddr;
      if (lk_hit) lru[l_set] <= ~l_match[1];
      if (inv_all) begin
        for (int s = 0; s < SETS; s++) vld[s] <= 2'b00;
      end else if (fill_en) begin
        vld[f_set][f_way] <= 1'b1;
        lru[f_set]        <= ~f_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (f_do) begin
      tag[f_set][f_way] <= f_tag;
      ppn[f_set][f_way] <= fill_ppn;
    end
  end

  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));

  p_idle_nohit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_hit);

  p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_do && lk_valid && lk_vaddr[VA_W-1:OFF_W] == fill_vpn)
      |=> (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_ppn)));

  p_single_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_match));

  p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);
endmodule

// File: tb/test_tlb2w.sv
module test_tlb2w;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        inv_all = 0, lk_valid = 0, fill_en = 0;
  logic [15:0] lk_vaddr = 0;
  logic [7:0]  fill_vpn = 0, fill_ppn = 0;
  logic        lk_hit;
  logic [15:0] lk_paddr;

  int n_vec = 0, n_bad = 0;

  bit       mv [4][2];
  bit [5:0] mt [4][2];
  bit [7:0] mp [4][2];
  bit       mlru [4];

  tlb2w i_tlb2w (.clk(clk), .rst_n(rst_n), .inv_all(inv_all), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) mv[s][w] = 0;
  endtask

  task automatic do_fill(input bit [7:0] vpn, input bit [7:0] pn);
    int s, w;
    bit [5:0] t;
    s = vpn[1:0]; t = vpn[7:2];
    if (mv[s][0] && mt[s][0] == t) w = 0;
    else if (mv[s][1] && mt[s][1] == t) w = 1;
    else if (!mv[s][0]) w = 0;
    else if (!mv[s][1]) w = 1;
    else w = mlru[s];
    mv[s][w] = 1; mt[s][w] = t; mp[s][w] = pn; mlru[s] = (w == 0);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_ppn = pn;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic do_inv(input bit with_fill, input bit [7:0] vpn);
    @(negedge clk);
    inv_all = 1; fill_en = with_fill; fill_vpn = vpn; fill_ppn = 8'hC3;
    @(negedge clk);
    inv_all = 0; fill_en = 0;
    model_clear();
  endtask

  task automatic do_lookup(input bit [15:0] va, input string req);
    int s, hw;
    bit [5:0] t;
    bit [15:0] exp_pa;
    s = va[9:8]; t = va[15:10]; hw = -1;
    for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
    exp_pa = (hw >= 0) ? {mp[s][hw], va[7:0]} : {8'h00, va[7:0]};
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va;
    @(negedge clk);
    check(lk_hit == (hw >= 0), {req, " hit"}, 32'(lk_hit), 32'(hw >= 0));
    check(lk_paddr == exp_pa, {req, " paddr"}, 32'(lk_paddr), 32'(exp_pa));
    lk_valid = 0;
    if (hw >= 0) mlru[s] = (hw == 0);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 256; v++) do_lookup({v[7:0], v[7:0] ^ 8'h5A}, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    for (int s = 0; s < 4; s++) mlru[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(lk_hit == 0, "R8 reset no hit", 32'(lk_hit), 0);
    sweep("R8 empty after reset");

    do_fill(8'h4C, 8'h30);
    do_fill(8'hA9, 8'h72);
    do_fill(8'h7E, 8'h95);
    do_fill(8'hFF, 8'h20);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = 16'h7E85;
    @(negedge clk);
    check(lk_hit == 1 && lk_paddr == 16'h9585, "R9 0x7E85", 32'(lk_paddr), 32'h9585);
    lk_valid = 0;
    sweep("R1 R2 R3 loaded sweep");

    do_fill(8'h05, 8'h11);
    do_lookup(16'hA912, "R7 touch way0");
    do_fill(8'h09, 8'h22);
    do_lookup(16'h0533, "R6 evicted");
    check(lk_hit == 0, "R6 evicted way1 entry", 32'(lk_hit), 0);
    do_lookup(16'hA944, "R6 kept");
    check(lk_hit == 1, "R6 recent way0 kept", 32'(lk_hit), 1);
    do_fill(8'h09, 8'h44);
    do_lookup(16'h0901, "R5 overwrite");
    check(lk_paddr == 16'h4401, "R5 new ppn", 32'(lk_paddr), 32'h4401);
    do_lookup(16'hA902, "R5 other way kept");
    check(lk_hit == 1, "R5 no eviction", 32'(lk_hit), 1);

    do_inv(0, 0);
    sweep("R8 after invalidate");
    do_inv(1, 8'h4C);
    do_lookup(16'h4C00, "R8 inv beats fill");
    check(lk_hit == 0, "R8 inv beats fill", 32'(lk_hit), 0);

    do_fill(8'h4C, 8'h30);
    do_inv(0, 0);
    do_lookup(16'h4C10, "R3 tag match invalid");
    check(lk_hit == 0, "R3 stale tag misses", 32'(lk_hit), 0);

    for (int i = 0; i < 3000; i++) begin
      int op;
      bit [7:0] vpn;
      op = int'($urandom_range(0, 99));
      vpn = {4'b0, 2'($urandom), 2'($urandom)};
      if ($urandom_range(0, 7) == 0) vpn = 8'($urandom);
      if (op < 45) do_fill(vpn, 8'($urandom));
      else if (op < 99) do_lookup({vpn, 8'($urandom)}, "R4 R6 R7 random");
      else do_inv(0, 0);
    end
    sweep("R3 final sweep");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule